// File: doc/BRIEF.md
# Double-Buffered Transmit Gate Sequencer

This block drives the eight transmit-priority gates of one port in a time-aware shaper. A local command store holds gate commands. Each command pairs a mask of the priorities allowed to transmit with a hold time counted in transmit units. A periodic cycle-start pulse from an external time base restarts the list at its first entry. The engine then walks the list, one command after another, as each hold time runs out.

The store is split into two banks, so a new schedule can be written into one bank while the other one runs. A select input names the bank that should be used next. The engine adopts that bank only on a cycle-start pulse, and a status output shows which bank is actually in use. Software rewrites a bank only after that status output matches its selection.

A single-bank mode pins the engine to bank 0. Hold times count bytes on a gigabit link and nibbles on a slower link. A command with a zero hold time keeps its mask until the next cycle start. While gating is off, every priority may transmit.

Top module: `tx_gate_sequencer`

States of the engine, in `gsq_fsm`:
- OFF: gating is disabled and all gates are open.
- WAIT: gating is enabled but no cycle start has arrived yet, so all gates stay open.
- RUN: a command with a nonzero hold time is counting down.
- HOLD: the engine has reached a zero-length command or run past the end of the bank, and it keeps the current mask.

Transitions:
- DISABLE: any state goes to OFF when either enable input is low.
- ENABLE: OFF goes to WAIT.
- RESTART: WAIT, RUN or HOLD, on a cycle start, loads command 0 of the selected bank. The engine goes to RUN if that command's hold time is nonzero and to HOLD if it is zero.
- STEP: RUN, on the tick that uses up the hold time, loads the next command. The engine stays in RUN if the new hold time is nonzero and goes to HOLD if it is zero.
- OVERRUN: RUN goes to HOLD and sets the error flag when the last word of the bank expires.

## Requirements
- R1: A command word carries its hold time in bits 21:8 and its priority mask in bits 7:0. Bit 6 of the host write address selects the bank and bits 5:0 select the word, so bank 1 starts at address 64.
- R2: When `glb_enable` or `port_enable` is low, `allow` is 8'hFF from the next cycle on. After gating is enabled again, `allow` stays 8'hFF until the first cycle start, and unit strobes have no effect during that time.
- R3: A cycle start while gating is enabled makes the selected bank active. From the next cycle, `allow` shows the mask of command 0 of that bank, and that command's hold time is loaded.
- R4: A command with hold time D ≥ 1 stays in force for exactly D counting strobes. In the cycle after the D-th strobe, `allow` shows the next command's mask.
- R5: With `link_gig` = 1, only `byte_stb` counts and `nib_stb` is ignored. With `link_gig` = 0, only `nib_stb` counts and `byte_stb` is ignored.
- R6: A command with hold time 0 keeps its mask whatever strobes arrive, until the next cycle start.
- R7: `active_bank` changes only on a cycle start. Changing `bank_select` in the middle of a cycle changes neither `active_bank` nor `allow`.
- R8: With `single_bank` = 1, a cycle start always activates bank 0 and `bank_select` is ignored.
- R9: If the last word of the active bank (word 63) expires with a nonzero hold time, `addr_err` rises one cycle later and the last mask is held. `addr_err` stays set until reset, and later cycle starts do not clear it.
- R10: `pri_active` equals `tx_pending & allow` in the same cycle.
- R11: During and right after reset, `allow` is 8'hFF, `active_bank` is 0 and `addr_err` is 0.
- R12: A cycle start in the same cycle as a counting strobe restarts the list, and the strobe is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_en | input | 1 | Host write strobe into the command store |
| cmd_wr_addr | input | 7 | Host write address: bit 6 is the bank, bits 5:0 the word |
| cmd_wr_data | input | 22 | Command word: hold time in bits 21:8, mask in bits 7:0 |
| glb_enable | input | 1 | Global gating enable |
| port_enable | input | 1 | Per-port gating enable |
| bank_select | input | 1 | Bank to adopt at the next cycle start |
| single_bank | input | 1 | 1 pins the engine to bank 0 |
| link_gig | input | 1 | 1 selects gigabit (byte) counting, 0 selects nibble counting |
| byte_stb | input | 1 | One pulse per byte time |
| nib_stb | input | 1 | One pulse per nibble time |
| cycle_start | input | 1 | Cycle-start pulse from the time base |
| tx_pending | input | 8 | Priorities that have frames waiting |
| allow | output | 8 | Priority-allow vector |
| pri_active | output | 8 | Priorities that are pending and allowed |
| active_bank | output | 1 | Bank currently in use |
| addr_err | output | 1 | Sticky flag for running past the end of a bank |

## Verification
A wrong count or index shows at `allow` in the cycle after the faulty strobe: the mask changes one strobe early or late, or it changes during a zero-length command. A wrong bank register shows at `active_bank` and in the mask that `allow` presents one cycle after the cycle start. The bench can tell the two banks apart because they hold distinct masks. A missing or premature overrun shows at `addr_err` exactly one cycle after word 63 expires. Because the flag is sticky, a wrongly cleared flag is visible at any later cycle start.

// File: rtl/gsq_pkg.sv
package gsq_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2,
        ST_HOLD = 2'd3
    } gsq_state_e;
endpackage

// File: rtl/gsq_cmd_ram.sv
module gsq_cmd_ram #(
    parameter int BANK_DEPTH = 64,
    parameter int WORD_W     = 22,
    localparam int IDX_W     = $clog2(BANK_DEPTH),
    localparam int AW        = IDX_W + 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] bank_rd [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [WORD_W-1:0] mem [BANK_DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr[AW-1] == 1'(b)))
                mem[wr_addr[IDX_W-1:0]] <= wr_data;
        end

        assign bank_rd[b] = mem[rd_addr[IDX_W-1:0]];
    end

    assign rd_data = bank_rd[rd_addr[AW-1]];
endmodule

// File: rtl/gsq_unit_tick.sv
module gsq_unit_tick (
    input  logic link_gig,
    input  logic byte_stb,
    input  logic nib_stb,
    output logic unit_tick
);
    // Gigabit links count bytes; slower links count nibbles.
    always_comb begin
        unique case (link_gig)
            1'b1:    unit_tick = byte_stb;
            default: unit_tick = nib_stb;
        endcase
    end
endmodule

// File: rtl/gsq_fsm.sv
module gsq_fsm
    import gsq_pkg::*;
#(
    parameter int PRI_W      = 8,
    parameter int DUR_W      = 14,
    parameter int BANK_DEPTH = 64,
    localparam int IDX_W     = $clog2(BANK_DEPTH),
    localparam int AW        = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_on,
    input  logic             cycle_start,
    input  logic             unit_tick,
    input  logic             sel_bank,
    input  logic [DUR_W-1:0] rd_dur,
    input  logic [PRI_W-1:0] rd_mask,
    output logic [AW-1:0]    rd_addr,
    output logic [PRI_W-1:0] allow_o,
    output logic             active_bank_o,
    output logic             addr_err_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BANK_DEPTH - 1);
    localparam logic [DUR_W-1:0] ONE_UNIT = DUR_W'(1);

    gsq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [DUR_W-1:0] cnt_q, cnt_d;
    logic [PRI_W-1:0] mask_q, mask_d;
    logic             bank_q, bank_d;
    logic             err_q, err_d;
    logic             rd_bank;
    logic [IDX_W-1:0] rd_idx;

    // Next-state and read-address logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        cnt_d   = cnt_q;
        mask_d  = mask_q;
        bank_d  = bank_q;
        err_d   = err_q;
        rd_bank = bank_q;
        rd_idx  = idx_q + IDX_W'(1);
        if (!gate_on) begin
            state_d = ST_OFF;                       // DISABLE
        end else if (cycle_start && (state_q != ST_OFF)) begin
            rd_bank = sel_bank;                     // RESTART
            rd_idx  = '0;
            bank_d  = sel_bank;
            idx_d   = '0;
            mask_d  = rd_mask;
            cnt_d   = rd_dur;
            state_d = (rd_dur == '0) ? ST_HOLD : ST_RUN;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_WAIT;         // ENABLE
                ST_WAIT: state_d = ST_WAIT;
                ST_RUN: begin
                    if (unit_tick) begin
                        if (cnt_q != ONE_UNIT) begin
                            cnt_d = cnt_q - ONE_UNIT;
                        end else if (idx_q == LAST_IDX) begin
                            err_d   = 1'b1;         // OVERRUN
                            state_d = ST_HOLD;
                        end else begin
                            idx_d   = rd_idx;       // STEP
                            mask_d  = rd_mask;
                            cnt_d   = rd_dur;
                            state_d = (rd_dur == '0) ? ST_HOLD : ST_RUN;
                        end
                    end
                end
                ST_HOLD: state_d = ST_HOLD;
                default: state_d = ST_OFF;
            endcase
        end
    end

    assign rd_addr = {rd_bank, rd_idx};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            idx_q   <= '0;
            cnt_q   <= '0;
            mask_q  <= '1;
            bank_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            cnt_q   <= cnt_d;
            mask_q  <= mask_d;
            bank_q  <= bank_d;
            err_q   <= err_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_RUN, ST_HOLD: allow_o = mask_q;
            default:         allow_o = '1;
        endcase
        active_bank_o = bank_q;
        addr_err_o    = err_q;
    end

    a_r2_off_opens_all: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_on |=> (allow_o == '1));

    a_r7_bank_only_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_start |=> $stable(active_bank_o));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err_o |=> addr_err_o);

    a_r6_hold_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && gate_on && !cycle_start) |=> $stable(allow_o));

    a_r4_idle_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && gate_on && !cycle_start && !unit_tick) |=> $stable(cnt_q));
endmodule

// File: rtl/tx_gate_sequencer.sv
module tx_gate_sequencer #(
    parameter int PRI_W      = 8,
    parameter int DUR_W      = 14,
    parameter int BANK_DEPTH = 64,
    localparam int WORD_W    = DUR_W + PRI_W,
    localparam int IDX_W     = $clog2(BANK_DEPTH),
    localparam int AW        = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_en,
    input  logic [AW-1:0]     cmd_wr_addr,
    input  logic [WORD_W-1:0] cmd_wr_data,
    input  logic              glb_enable,
    input  logic              port_enable,
    input  logic              bank_select,
    input  logic              single_bank,
    input  logic              link_gig,
    input  logic              byte_stb,
    input  logic              nib_stb,
    input  logic              cycle_start,
    input  logic [PRI_W-1:0]  tx_pending,
    output logic [PRI_W-1:0]  allow,
    output logic [PRI_W-1:0]  pri_active,
    output logic              active_bank,
    output logic              addr_err
);
    logic              unit_tick;
    logic [AW-1:0]     rd_addr;
    logic [WORD_W-1:0] rd_data;
    logic              gate_on;
    logic              sel_bank;

    assign gate_on  = glb_enable & port_enable;
    assign sel_bank = single_bank ? 1'b0 : bank_select;

    gsq_cmd_ram #(
        .BANK_DEPTH (BANK_DEPTH),
        .WORD_W     (WORD_W)
    ) u_ram (
        .clk     (clk),
        .wr_en   (cmd_wr_en),
        .wr_addr (cmd_wr_addr),
        .wr_data (cmd_wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    gsq_unit_tick u_tick (
        .link_gig  (link_gig),
        .byte_stb  (byte_stb),
        .nib_stb   (nib_stb),
        .unit_tick (unit_tick)
    );

    gsq_fsm #(
        .PRI_W      (PRI_W),
        .DUR_W      (DUR_W),
        .BANK_DEPTH (BANK_DEPTH)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .gate_on       (gate_on),
        .cycle_start   (cycle_start),
        .unit_tick     (unit_tick),
        .sel_bank      (sel_bank),
        .rd_dur        (rd_data[WORD_W-1:PRI_W]),
        .rd_mask       (rd_data[PRI_W-1:0]),
        .rd_addr       (rd_addr),
        .allow_o       (allow),
        .active_bank_o (active_bank),
        .addr_err_o    (addr_err)
    );

    assign pri_active = tx_pending & allow;
endmodule

// File: tb/tx_gate_sequencer_tb.sv
`timescale 1ns/1ps
module tx_gate_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_wr_en;
    logic [6:0]  cmd_wr_addr;
    logic [21:0] cmd_wr_data;
    logic        glb_enable, port_enable, bank_select, single_bank, link_gig;
    logic        byte_stb, nib_stb, cycle_start;
    logic [7:0]  tx_pending;
    logic [7:0]  allow, pri_active;
    logic        active_bank, addr_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tx_gate_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_addr(cmd_wr_addr),
        .cmd_wr_data(cmd_wr_data), .glb_enable(glb_enable), .port_enable(port_enable),
        .bank_select(bank_select), .single_bank(single_bank), .link_gig(link_gig),
        .byte_stb(byte_stb), .nib_stb(nib_stb), .cycle_start(cycle_start),
        .tx_pending(tx_pending), .allow(allow), .pri_active(pri_active),
        .active_bank(active_bank), .addr_err(addr_err)
    );

    // {cycle_start, byte_stb, nib_stb, expected bank, expected allow}
    localparam logic [11:0] VEC [9] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 8'h01},  // R3 restart, R1 mask field
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h01},  // R4 count 2 -> 1
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h01},  // R5 nibble ignored on gigabit
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h02},  // R4 step after 2 strobes
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h02},
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h02},
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h04},  // R4 step after 3 strobes, R1 duration field
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h04},  // R6 zero-length holds
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h04}   // R6
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic cs, input logic bs, input logic ns);
        cycle_start = cs;
        byte_stb    = bs;
        nib_stb     = ns;
        @(negedge clk);
        cycle_start = 1'b0;
        byte_stb    = 1'b0;
        nib_stb     = 1'b0;
    endtask

    task automatic wr(input int addr, input int dur, input int mask);
        cmd_wr_en   = 1'b1;
        cmd_wr_addr = 7'(addr);
        cmd_wr_data = {14'(dur), 8'(mask)};
        @(negedge clk);
        cmd_wr_en   = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_wr_en = 1'b0; cmd_wr_addr = '0; cmd_wr_data = '0;
        glb_enable = 1'b0; port_enable = 1'b0; bank_select = 1'b0; single_bank = 1'b0;
        link_gig = 1'b1; byte_stb = 1'b0; nib_stb = 1'b0; cycle_start = 1'b0; tx_pending = '0;
        repeat (3) @(negedge clk);
        chk("R11 allow in reset", 32'(allow), 32'hFF);
        chk("R11 bank in reset", 32'(active_bank), 0);
        chk("R11 err in reset", 32'(addr_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 allow after reset", 32'(allow), 32'hFF);

        wr(0, 2, 8'h01); wr(1, 3, 8'h02); wr(2, 0, 8'h04);
        wr(64, 1, 8'h10); wr(65, 0, 8'h20);

        glb_enable = 1'b1; port_enable = 1'b1;
        cyc(0, 0, 0);
        cyc(0, 1, 0);
        chk("R2 open before first start", 32'(allow), 32'hFF);

        for (int i = 0; i < 9; i++) begin
            cyc(VEC[i][11], VEC[i][10], VEC[i][9]);
            chk("R1 R3 R4 R5 R6 table allow", 32'(allow), 32'(VEC[i][7:0]));
            chk("R3 R7 table bank", 32'(active_bank), 32'(VEC[i][8]));
        end

        tx_pending = 8'h0F;
        #1 chk("R10 pri_active", 32'(pri_active), 32'h04);
        tx_pending = 8'hF0;
        #1 chk("R10 pri_active none", 32'(pri_active), 32'h00);
        tx_pending = '0;

        bank_select = 1'b1;
        cyc(0, 1, 0);
        chk("R7 bank held mid-cycle", 32'(active_bank), 0);
        chk("R7 allow held mid-cycle", 32'(allow), 32'h04);
        cyc(1, 0, 0);
        chk("R3 bank switched", 32'(active_bank), 1);
        chk("R3 bank1 cmd0", 32'(allow), 32'h10);
        cyc(0, 1, 0);
        chk("R4 bank1 step", 32'(allow), 32'h20);

        cyc(1, 0, 0);
        cyc(1, 1, 0);
        chk("R12 start beats strobe", 32'(allow), 32'h10);
        cyc(0, 1, 0);
        chk("R12 count intact", 32'(allow), 32'h20);

        link_gig = 1'b0; bank_select = 1'b0;
        cyc(1, 0, 0);
        chk("R5 restart bank0", 32'(allow), 32'h01);
        cyc(0, 1, 0);
        cyc(0, 0, 1);
        cyc(0, 1, 0);
        chk("R5 byte ignored at low speed", 32'(allow), 32'h01);
        cyc(0, 0, 1);
        chk("R5 nibble counts", 32'(allow), 32'h02);

        single_bank = 1'b1; bank_select = 1'b1;
        cyc(1, 0, 0);
        chk("R8 single bank forces 0", 32'(active_bank), 0);
        chk("R8 single bank mask", 32'(allow), 32'h01);

        port_enable = 1'b0;
        cyc(0, 0, 0);
        chk("R2 port disable opens", 32'(allow), 32'hFF);
        cyc(1, 0, 0);
        chk("R2 start ignored when off", 32'(allow), 32'hFF);
        port_enable = 1'b1;
        cyc(0, 0, 0);
        chk("R2 wait after enable", 32'(allow), 32'hFF);
        cyc(1, 0, 0);
        chk("R2 runs after start", 32'(allow), 32'h01);
        glb_enable = 1'b0;
        cyc(0, 0, 0);
        chk("R2 global disable opens", 32'(allow), 32'hFF);
        glb_enable = 1'b1;
        cyc(0, 0, 0);

        single_bank = 1'b0; bank_select = 1'b0; link_gig = 1'b1;
        for (int w = 0; w < 64; w++) wr(w, 1, w + 1);
        cyc(1, 0, 0);
        chk("R9 first word", 32'(allow), 32'h01);
        for (int t = 0; t < 63; t++) cyc(0, 1, 0);
        chk("R9 last word mask", 32'(allow), 32'h40);
        chk("R9 no error yet", 32'(addr_err), 0);
        cyc(0, 1, 0);
        chk("R9 overrun flagged", 32'(addr_err), 1);
        chk("R9 last mask held", 32'(allow), 32'h40);
        cyc(0, 1, 0);
        chk("R9 still held", 32'(allow), 32'h40);
        cyc(1, 0, 0);
        chk("R9 sticky across start", 32'(addr_err), 1);
        chk("R9 restart mask", 32'(allow), 32'h01);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule